// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Demodulator

This block recovers a short reply from a passive tag whose answer carries no framing. The reply's length must be known in advance. The receive path feeds the block a single thresholded level, which toggles rapidly while the tag's subcarrier is present and stays quiet otherwise. The transmitter emits a strobe at the end of its own frame. From that strobe the block waits a fixed turnaround of 490 ticks. It then slices time into back-to-back windows of 150 ticks each and counts how often the input level changes inside each window.

A window whose change count lies strictly between 20 and 60 is taken as a 1 bit. The nominal count is about 42. Every other count is taken as a 0. Decoded bits are packed least significant first into a 16-bit word. The word and the number of bits received are presented together with a single-cycle valid pulse. With no start or stop marker, a silent input and a tag sending zeros cannot be told apart, so the block always samples exactly the requested number of windows.

Top module: `edge_bit_demod`

## Requirements
- R1: A requested length above 16 is treated as 16. The reported bit count equals the requested length after this limit.
- R2: The first bit window opens 490 ticks after the start strobe. Each window lasts 150 ticks, with no gap between windows. Exactly the requested number of windows is sampled. For a length of 0, the result is reported at the end of the turnaround.
- R3: A window whose edge count is greater than 20 and less than 60 decodes as 1. A count of 20 or below, or of 60 or above, decodes as 0.
- R4: The bit from window k is placed in bit k of the data word (window 0 in bit 0). Every data bit at or above the reported count reads 0.
- R5: The per-window edge counter stops at 63 and does not wrap, so a window with far more than 60 edges decodes as 0.
- R6: valid_o is high for exactly one cycle per reception. It rises together with the new data and count. Both outputs hold their value between receptions.
- R7: A start strobe clears the data word and the count on the following cycle. It also restarts timing, even in the middle of a reception.
- R8: Turnaround and window timing advance only on cycles where tick_i is high. With tick_i held low, no result is ever produced.
- R9: An input with no level changes yields an all-zero word, with the full requested count reported.
- R10: The input passes through a two-flop synchronizer. Each change of the synchronized level adds one to the edge count, and the count does not move without such a change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame-end reference strobe; begins a reception |
| nbits_i | input | 5 | Number of bits expected, sampled with start_i |
| tick_i | input | 1 | Timebase enable; one tick per timing unit |
| din_i | input | 1 | Thresholded receive level (asynchronous) |
| data_o | output | 16 | Received bits, first bit in bit 0 |
| count_o | output | 5 | Number of bits received |
| valid_o | output | 1 | One-cycle pulse when data_o and count_o update |

## Verification
Several properties are checked on every cycle: that the valid pulse lasts one cycle, that the outputs clear after a start strobe and otherwise hold between results, that windows close only on tick cycles, that the reported count never exceeds 16 and no data bit lies above it, and that the edge counter moves only on a synchronized level change and holds at 63. The numeric band edges (20, 21, 59, 60), the 490/150 tick schedule, the least-significant-first packing, and the equivalence of silence and zeros depend on what is fed into each window. Only the bench's directed scenarios show these, including a halved tick rate, a stalled tick, and a restart in the middle of a frame.

// File: rtl/edm_pkg.sv
package edm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_RECV = 2'd2
  } edm_state_e;

  // Requested length after the upper limit is applied.
  function automatic int clamp_len(input int req, input int max_bits);
    return (req > max_bits) ? max_bits : req;
  endfunction

  // Band decision: strictly above lo and strictly below hi.
  function automatic logic in_band(input int cnt, input int lo, input int hi);
    return (cnt > lo) && (cnt < hi);
  endfunction

endpackage

// File: rtl/edm_sync.sv
module edm_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic edge_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= din_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign edge_o = sync_q ^ prev_q;
endmodule

// File: rtl/edm_edge_count.sv
module edm_edge_count #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic             edge_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (clear_i) begin
      cnt_o <= '0;
    end else if (load_i) begin
      cnt_o <= edge_i ? CNT_W'(1) : '0;
    end else if (edge_i && (cnt_o != SAT)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/edm_timer.sv
module edm_timer
  import edm_pkg::*;
#(
  parameter int WAIT_TICKS = 490,
  parameter int WIN_TICKS  = 150,
  parameter int IDX_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [IDX_W-1:0] req_i,
  output logic             turn_done_o,
  output logic             win_close_o,
  output logic             finish_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int LONGEST = (WAIT_TICKS > WIN_TICKS) ? WAIT_TICKS : WIN_TICKS;
  localparam int TW      = $clog2(LONGEST + 1);
  localparam logic [TW-1:0] TURN_LAST = TW'(WAIT_TICKS - 1);
  localparam logic [TW-1:0] WIN_LAST  = TW'(WIN_TICKS - 1);

  edm_state_e       state_q;
  logic [TW-1:0]    tcnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_win;

  assign turn_done_o = (state_q == ST_TURN) && tick_i && (tcnt_q == TURN_LAST) && !start_i;
  assign win_close_o = (state_q == ST_RECV) && tick_i && (tcnt_q == WIN_LAST) && !start_i;
  assign last_win    = ((idx_q + 1'b1) == req_i);
  assign finish_o    = (win_close_o && last_win) || (turn_done_o && (req_i == '0));
  assign idx_o       = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      idx_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_TURN;
      tcnt_q  <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_TURN: if (tick_i) begin
          if (turn_done_o) begin
            tcnt_q  <= '0;
            state_q <= (req_i == '0) ? ST_IDLE : ST_RECV;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_RECV: if (tick_i) begin
          if (win_close_o) begin
            tcnt_q <= '0;
            if (last_win) state_q <= ST_IDLE;
            else          idx_q   <= idx_q + 1'b1;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        default: begin
          tcnt_q <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/edge_bit_demod.sv
module edge_bit_demod
  import edm_pkg::*;
#(
  parameter int MAX_BITS   = 16,
  parameter int REQ_W      = 5,
  parameter int WAIT_TICKS = 490,
  parameter int WIN_TICKS  = 150,
  parameter int BAND_LO    = 20,
  parameter int BAND_HI    = 60,
  parameter int CNT_W      = 6,
  localparam int IDX_W     = $clog2(MAX_BITS + 1),
  localparam int POS_W     = $clog2(MAX_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [REQ_W-1:0]    nbits_i,
  input  logic                tick_i,
  input  logic                din_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic [IDX_W-1:0]    count_o,
  output logic                valid_o
);
  // Named internal events (observed by the bound checker).
  logic                edge_pulse;
  logic                turn_done;
  logic                win_close;
  logic                finish;
  logic                cnt_load;
  logic                bit_val;
  logic [CNT_W-1:0]    edge_cnt;
  logic [IDX_W-1:0]    idx;
  logic [IDX_W-1:0]    req_q;
  logic [MAX_BITS-1:0] acc_q;
  logic [MAX_BITS-1:0] acc_next;

  edm_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (din_i),
    .edge_o (edge_pulse)
  );

  edm_timer #(
    .WAIT_TICKS (WAIT_TICKS),
    .WIN_TICKS  (WIN_TICKS),
    .IDX_W      (IDX_W)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .tick_i      (tick_i),
    .req_i       (req_q),
    .turn_done_o (turn_done),
    .win_close_o (win_close),
    .finish_o    (finish),
    .idx_o       (idx)
  );

  assign cnt_load = turn_done | win_close;

  edm_edge_count #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_i),
    .load_i  (cnt_load),
    .edge_i  (edge_pulse),
    .cnt_o   (edge_cnt)
  );

  assign bit_val = in_band(int'(edge_cnt), BAND_LO, BAND_HI);

  always_comb begin
    acc_next = acc_q;
    if (win_close) acc_next[idx[POS_W-1:0]] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      acc_q   <= '0;
      data_o  <= '0;
      count_o <= '0;
      valid_o <= 1'b0;
    end else if (start_i) begin
      req_q   <= IDX_W'(clamp_len(int'(nbits_i), MAX_BITS));
      acc_q   <= '0;
      data_o  <= '0;
      count_o <= '0;
      valid_o <= 1'b0;
    end else begin
      acc_q   <= acc_next;
      valid_o <= finish;
      if (finish) begin
        data_o  <= acc_next;
        count_o <= req_q;
      end
    end
  end
endmodule

// File: rtl/edm_checker.sv
module edm_checker #(
  parameter int MAX_BITS = 16,
  parameter int IDX_W    = 5,
  parameter int CNT_W    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                tick_i,
  input logic                valid_o,
  input logic [MAX_BITS-1:0] data_o,
  input logic [IDX_W-1:0]    count_o,
  input logic                win_close,
  input logic                cnt_load,
  input logic                edge_pulse,
  input logic [CNT_W-1:0]    edge_cnt
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R6

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !$past(start_i)) |-> ($stable(data_o) && $stable(count_o))); // R6

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (data_o == '0 && count_o == '0 && !valid_o)); // R7

  AST_CLOSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |-> tick_i); // R8

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(count_o) <= MAX_BITS)); // R1

  AST_NO_DATA_ABOVE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((data_o >> count_o) == '0)); // R4

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cnt == SAT && !cnt_load && !start_i) |=> (edge_cnt == SAT)); // R5

  AST_COUNT_ON_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_pulse && !cnt_load && !start_i) |=> $stable(edge_cnt)); // R10
endmodule

bind edge_bit_demod edm_checker #(
  .MAX_BITS (MAX_BITS),
  .IDX_W    (IDX_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .tick_i     (tick_i),
  .valid_o    (valid_o),
  .data_o     (data_o),
  .count_o    (count_o),
  .win_close  (win_close),
  .cnt_load   (cnt_load),
  .edge_pulse (edge_pulse),
  .edge_cnt   (edge_cnt)
);

// File: tb/sim_edge_bit_demod.sv
`timescale 1ns/1ps
module sim_edge_bit_demod;
  localparam int WAIT_T = 490;
  localparam int WIN_T  = 150;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  nbits_i = '0;
  logic        tick_i = 1'b0;
  logic        din_i = 1'b0;
  logic [15:0] data_o;
  logic [4:0]  count_o;
  logic        valid_o;

  int n_chk = 0;
  int n_fail = 0;
  int tick_div = 1;
  int tphase = 0;
  int ecnt [16];

  always #2 clk = ~clk;

  edge_bit_demod u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .nbits_i (nbits_i),
    .tick_i  (tick_i),
    .din_i   (din_i),
    .data_o  (data_o),
    .count_o (count_o),
    .valid_o (valid_o)
  );

  // Tick generator: one tick every tick_div cycles, none when tick_div is 0.
  always @(negedge clk) begin
    if (tick_div <= 0) begin
      tick_i <= 1'b0;
    end else begin
      tphase = (tphase + 1 >= tick_div) ? 0 : tphase + 1;
      tick_i <= (tphase == 0);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_pattern(input logic [15:0] bits, input int ones);
    for (int i = 0; i < 16; i++) ecnt[i] = bits[i] ? ones : 0;
  endtask

  task automatic pulse_start(input int nb);
    @(negedge clk);
    nbits_i = 5'(nb);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // One reception: feed ecnt[k] toggles into window k, then check the result.
  task automatic run_frame(input int nb, input int div, input logic [15:0] exp_data,
                           input int exp_cnt, input string req);
    int windows;
    int got;
    tick_div = div;
    windows = (nb > 16) ? 16 : nb;
    pulse_start(nb);
    check(data_o == 16'h0 && count_o == 5'd0 && !valid_o, "R7",
          "outputs cleared after start", int'(data_o), 0);
    repeat (WAIT_T * div - 1) @(negedge clk);
    for (int k = 0; k < windows; k++) begin
      int sp;
      int used;
      sp = (ecnt[k] > 60) ? 1 : 2;
      used = 10 + ecnt[k] * sp;
      repeat (10) @(negedge clk);
      for (int j = 0; j < ecnt[k]; j++) begin
        din_i = ~din_i;
        repeat (sp) @(negedge clk);
      end
      repeat (WIN_T * div - used) @(negedge clk);
    end
    got = 0;
    for (int w = 0; w < 40; w++) begin
      if (valid_o) begin
        got = 1;
        break;
      end
      @(negedge clk);
    end
    check(got == 1, req, "valid after last window", got, 1);
    check(data_o == exp_data, req, "data word", int'(data_o), int'(exp_data));
    check(int'(count_o) == exp_cnt, req, "bit count", int'(count_o), exp_cnt);
    @(negedge clk);
    check(!valid_o, "R6", "valid lasts one cycle", int'(valid_o), 0);
    check(data_o == exp_data, "R6", "data holds after valid", int'(data_o), int'(exp_data));
  endtask

  task automatic t_reset;
    check(data_o == 16'h0, "R6", "reset data", int'(data_o), 0);
    check(count_o == 5'd0, "R6", "reset count", int'(count_o), 0);
    check(!valid_o, "R6", "reset valid", int'(valid_o), 0);
  endtask

  task automatic t_full_word;  // R2 R4 R10: 16 windows, nominal 42 edges for a one
    set_pattern(16'hA5C3, 42);
    run_frame(16, 1, 16'hA5C3, 16, "R4");
  endtask

  task automatic t_band_edges;  // R3: counts 20,21,59,60 -> 0,1,1,0
    set_pattern(16'h0, 0);
    ecnt[0] = 20; ecnt[1] = 21; ecnt[2] = 59; ecnt[3] = 60; ecnt[4] = 5;
    run_frame(5, 1, 16'b00110, 5, "R3");
  endtask

  task automatic t_saturate;  // R5: 100 edges stay out of the band
    set_pattern(16'h0, 0);
    ecnt[0] = 100; ecnt[1] = 42; ecnt[2] = 120;
    run_frame(3, 1, 16'b010, 3, "R5");
  endtask

  task automatic t_clamp;  // R1: 25 requested -> 16 windows
    set_pattern(16'h3C5A, 40);
    run_frame(25, 1, 16'h3C5A, 16, "R1");
  endtask

  task automatic t_short;  // R2: only 5 windows, later stimulus ignored
    set_pattern(16'hFFFF, 42);
    run_frame(5, 1, 16'h001F, 5, "R2");
  endtask

  task automatic t_silence;  // R9
    set_pattern(16'h0, 0);
    run_frame(8, 1, 16'h0000, 8, "R9");
  endtask

  task automatic t_zero_len;  // R2: length 0 reports at end of turnaround
    set_pattern(16'h0, 0);
    run_frame(0, 1, 16'h0000, 0, "R2");
  endtask

  task automatic t_half_tick;  // R8: half tick rate doubles every window
    set_pattern(16'h00B6, 30);
    run_frame(8, 2, 16'h00B6, 8, "R8");
  endtask

  task automatic t_stall;  // R8: no tick, no result
    int seen;
    seen = 0;
    tick_div = 0;
    pulse_start(4);
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (valid_o) seen = 1;
    end
    check(seen == 0, "R8", "no result without ticks", seen, 0);
    tick_div = 1;
  endtask

  task automatic t_restart;  // R7: restart mid-reception
    tick_div = 1;
    set_pattern(16'hFFFF, 42);
    pulse_start(16);
    repeat (1200) @(negedge clk);
    check(!valid_o, "R7", "no result before restart", int'(valid_o), 0);
    set_pattern(16'h0002, 45);
    run_frame(2, 1, 16'h0002, 2, "R7");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ecnt[i] = 0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_full_word();
    t_band_edges();
    t_saturate();
    t_clamp();
    t_short();
    t_silence();
    t_zero_len();
    t_half_tick();
    t_stall();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule